// File: doc/BRIEF.md
# Character LCD Instruction Executor

This block sits behind the host bus port of a character LCD controller. It takes strobed instruction bytes and data bytes, decodes each instruction by the position of its highest set bit, and carries out the display-control command set. It holds the mode registers: entry direction and auto-shift, display, cursor and blink enables, and bus width, line count and font height. It also keeps a display shift offset and one 7-bit address counter. The counter points into either an 80-byte display RAM or a 64-byte glyph RAM, whichever was addressed last.

Every accepted instruction or data access raises a busy flag for a fixed number of oscillator cycles. Clear and home use a long duration and all other commands a short one. Strobes that arrive while busy is high are dropped. A data access reads or writes the selected RAM at the counter and then steps the counter up or down, wrapping inside the active space. The LCD scan, the font ROM and the bus timing live in other blocks.

Top module: `lcd_cmd_exec`

## Requirements
- R1: After reset busy_o=0, ac_o=0, cg_sel_o=0, inc_o=1, auto_shift_o=0, disp_on_o=0, cursor_o=0, blink_o=0, bus8_o=1, two_line_o=0, font10_o=0, shift_ofs_o=0, rdata_o=0, and every display RAM byte holds 20h.
- R2: Instruction 01h writes 20h into all display RAM locations. It also sets ac_o=0, inc_o=1, shift_ofs_o=0 and cg_sel_o=0.
- R3: Instruction 0000_001x sets ac_o=0, shift_ofs_o=0 and cg_sel_o=0, and leaves the RAM contents unchanged.
- R4: 0000_01ab loads inc_o=a and auto_shift_o=b. 0000_1dcb loads disp_on_o=d, cursor_o=c and blink_o=b. 001f_ghxx loads bus8_o=f, two_line_o=g and font10_o=h.
- R5: An instruction byte (wr_i=1, rs_i=0) is decoded by its highest set bit; bits below the command's own fields are ignored; 00h does nothing and raises no busy.
- R6: 01aa_aaaa sets ac_o=a and cg_sel_o=1. 1aaa_aaaa sets cg_sel_o=0 and ac_o=a when a<80, or a-80 when a>=80.
- R7: A data write (wr_i=1, rs_i=1) stores data_i at ac_o in the selected RAM. Then ac_o steps +1 when inc_o=1 or -1 when inc_o=0, wrapping 79<->0 in display RAM and 63<->0 in glyph RAM.
- R8: A data read (rd_i=1, rs_i=1, wr_i=0) presents the selected RAM byte at ac_o on rdata_o from the cycle after acceptance, holds it until the next read, and steps ac_o as in R7.
- R9: With auto_shift_o=1, each display RAM data access also moves shift_ofs_o by +1 when inc_o=1 and by -1 when inc_o=0, modulo 80. Glyph RAM accesses leave shift_ofs_o unchanged.
- R10: 0001_sr_xx with s=0 steps ac_o by +1 (r=1) or -1 (r=0) with the wrap of R7. With s=1 it moves shift_ofs_o by -1 (r=1, right) or +1 (r=0, left) modulo 80 and leaves ac_o unchanged.
- R11: Each accepted command or data access holds busy_o high for exactly SHORT_CYC cycles, or LONG_CYC cycles for clear and home, starting the cycle after acceptance. A status strobe (rd_i=1, rs_i=0) changes nothing and raises no busy.
- R12: Strobes that arrive while busy_o=1 are ignored; state and RAM are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe |
| rs_i | input | 1 | 0 instruction/status, 1 data |
| data_i | input | 8 | Instruction or data byte |
| busy_o | output | 1 | Command executing |
| ac_o | output | 7 | Address counter |
| rdata_o | output | 8 | Last RAM byte read |
| cg_sel_o | output | 1 | 1 when glyph RAM is the active space |
| inc_o | output | 1 | Entry direction, 1 increments |
| auto_shift_o | output | 1 | Shift display on data access |
| disp_on_o | output | 1 | Display enable |
| cursor_o | output | 1 | Cursor enable |
| blink_o | output | 1 | Cursor blink enable |
| bus8_o | output | 1 | 8-bit bus width selected |
| two_line_o | output | 1 | Two-line mode |
| font10_o | output | 1 | Tall font selected |
| shift_ofs_o | output | 7 | Display shift offset, 0..79 |

## Verification
The bench drives the counter across both wrap points in both directions and in both RAM spaces. A design that wrapped at the power-of-two size would run into addresses 80..127 or leave 0..63 of the glyph space. It loads display addresses above 79, uses bytes with junk in their low bits, and sends 00h, so a decoder that matched bit patterns instead of the highest set bit would pick the wrong command. It holds a data strobe across the busy window and then reads the neighbouring location back: a design that accepted during busy would write twice and move the counter twice. Auto-shift is checked on glyph RAM accesses and the offset is checked wrapping below zero, so a design that shifted on every access or wrapped the offset wrongly shows a wrong offset.

// File: rtl/lcd_cmd_exec_pkg.sv
package lcd_cmd_exec_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP, OP_SHIFT,
    OP_FUNC, OP_CGADDR, OP_DDADDR, OP_WRITE, OP_READ
  } op_e;

  typedef struct packed {
    logic inc;
    logic auto_shift;
    logic disp_on;
    logic cursor;
    logic blink;
    logic bus8;
    logic two_line;
    logic font10;
  } mode_t;

  localparam mode_t MODE_RST = '{inc: 1'b1, auto_shift: 1'b0, disp_on: 1'b0,
                                  cursor: 1'b0, blink: 1'b0, bus8: 1'b1,
                                  two_line: 1'b0, font10: 1'b0};
endpackage

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
  import lcd_cmd_exec_pkg::*;
(
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       rs_i,
  input  logic [7:0] byte_i,
  output op_e        op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (wr_i) begin
      if (rs_i)           op_o = OP_WRITE;
      else if (byte_i[7]) op_o = OP_DDADDR;
      else if (byte_i[6]) op_o = OP_CGADDR;
      else if (byte_i[5]) op_o = OP_FUNC;
      else if (byte_i[4]) op_o = OP_SHIFT;
      else if (byte_i[3]) op_o = OP_DISP;
      else if (byte_i[2]) op_o = OP_ENTRY;
      else if (byte_i[1]) op_o = OP_HOME;
      else if (byte_i[0]) op_o = OP_CLEAR;
    end else if (rd_i && rs_i) begin
      op_o = OP_READ;
    end
  end
endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int SHORT_CYC = 20,
  parameter int LONG_CYC  = 820
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  output logic busy_o
);
  localparam int CW = $clog2(LONG_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= long_i ? CW'(LONG_CYC) : CW'(SHORT_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  p_no_start_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
endmodule

// File: rtl/lcd_byte_ram.sv
module lcd_byte_ram #(
  parameter int         DEPTH = 80,
  parameter int         AW    = 7,
  parameter logic [7:0] INIT  = 8'h20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
    end else if (clr_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

  p_wr_addr_ok_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (32'(addr_i) < DEPTH));
endmodule

// File: rtl/lcd_cmd_exec.sv
module lcd_cmd_exec
  import lcd_cmd_exec_pkg::*;
#(
  parameter int DD_DEPTH  = 80,
  parameter int CG_DEPTH  = 64,
  parameter int SHORT_CYC = 20,
  parameter int LONG_CYC  = 820
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       rs_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic [6:0] ac_o,
  output logic [7:0] rdata_o,
  output logic       cg_sel_o,
  output logic       inc_o,
  output logic       auto_shift_o,
  output logic       disp_on_o,
  output logic       cursor_o,
  output logic       blink_o,
  output logic       bus8_o,
  output logic       two_line_o,
  output logic       font10_o,
  output logic [6:0] shift_ofs_o
);
  localparam int AW  = 7;
  localparam int CGW = $clog2(CG_DEPTH);
  localparam logic [AW-1:0] DD_LAST = AW'(DD_DEPTH - 1);
  localparam logic [AW-1:0] CG_LAST = AW'(CG_DEPTH - 1);

  op_e           op_raw, op;
  mode_t         mode_q;
  logic [AW-1:0] ac_q, ofs_q, dd_load;
  logic          cg_sel_q;
  logic [7:0]    rdata_q, dd_rd, cg_rd;
  logic          dd_we, cg_we, dd_clr;

  function automatic logic [AW-1:0] wrap_step(logic [AW-1:0] a, logic up,
                                              logic [AW-1:0] last);
    if (up) return (a == last) ? '0 : a + AW'(1);
    else    return (a == '0) ? last : a - AW'(1);
  endfunction

  lcd_cmd_decode u_dec (
    .wr_i(wr_i), .rd_i(rd_i), .rs_i(rs_i), .byte_i(data_i), .op_o(op_raw)
  );

  assign op = busy_o ? OP_NONE : op_raw;

  lcd_busy_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(op != OP_NONE),
    .long_i(op == OP_CLEAR || op == OP_HOME),
    .busy_o(busy_o)
  );

  assign dd_we  = (op == OP_WRITE) && !cg_sel_q;
  assign cg_we  = (op == OP_WRITE) &&  cg_sel_q;
  assign dd_clr = (op == OP_CLEAR);

  lcd_byte_ram #(.DEPTH(DD_DEPTH), .AW(AW), .INIT(8'h20)) u_dd (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(dd_clr), .we_i(dd_we),
    .addr_i(ac_q), .wdata_i(data_i), .rdata_o(dd_rd)
  );

  lcd_byte_ram #(.DEPTH(CG_DEPTH), .AW(CGW), .INIT(8'h00)) u_cg (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(1'b0), .we_i(cg_we),
    .addr_i(ac_q[CGW-1:0]), .wdata_i(data_i), .rdata_o(cg_rd)
  );

  // out-of-range display address folds back into the 80-byte space
  assign dd_load = (data_i[AW-1:0] > DD_LAST) ? data_i[AW-1:0] - AW'(DD_DEPTH)
                                              : data_i[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RST;
      ac_q     <= '0;
      ofs_q    <= '0;
      cg_sel_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      case (op)
        OP_CLEAR: begin
          ac_q       <= '0;
          ofs_q      <= '0;
          cg_sel_q   <= 1'b0;
          mode_q.inc <= 1'b1;
        end
        OP_HOME: begin
          ac_q     <= '0;
          ofs_q    <= '0;
          cg_sel_q <= 1'b0;
        end
        OP_ENTRY: begin
          mode_q.inc        <= data_i[1];
          mode_q.auto_shift <= data_i[0];
        end
        OP_DISP: begin
          mode_q.disp_on <= data_i[2];
          mode_q.cursor  <= data_i[1];
          mode_q.blink   <= data_i[0];
        end
        OP_SHIFT: begin
          if (data_i[3]) ofs_q <= wrap_step(ofs_q, !data_i[2], DD_LAST);
          else           ac_q  <= wrap_step(ac_q, data_i[2],
                                            cg_sel_q ? CG_LAST : DD_LAST);
        end
        OP_FUNC: begin
          mode_q.bus8     <= data_i[4];
          mode_q.two_line <= data_i[3];
          mode_q.font10   <= data_i[2];
        end
        OP_CGADDR: begin
          ac_q     <= AW'(data_i[CGW-1:0]);
          cg_sel_q <= 1'b1;
        end
        OP_DDADDR: begin
          ac_q     <= dd_load;
          cg_sel_q <= 1'b0;
        end
        OP_WRITE, OP_READ: begin
          ac_q <= wrap_step(ac_q, mode_q.inc, cg_sel_q ? CG_LAST : DD_LAST);
          if (mode_q.auto_shift && !cg_sel_q)
            ofs_q <= wrap_step(ofs_q, mode_q.inc, DD_LAST);
          if (op == OP_READ) rdata_q <= cg_sel_q ? cg_rd : dd_rd;
        end
        default: ;
      endcase
    end
  end

  assign ac_o         = ac_q;
  assign shift_ofs_o  = ofs_q;
  assign cg_sel_o     = cg_sel_q;
  assign rdata_o      = rdata_q;
  assign inc_o        = mode_q.inc;
  assign auto_shift_o = mode_q.auto_shift;
  assign disp_on_o    = mode_q.disp_on;
  assign cursor_o     = mode_q.cursor;
  assign blink_o      = mode_q.blink;
  assign bus8_o       = mode_q.bus8;
  assign two_line_o   = mode_q.two_line;
  assign font10_o     = mode_q.font10;

  p_stable_while_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(ac_q) && $stable(ofs_q) && $stable(cg_sel_q) && $stable(mode_q)));

  p_busy_after_cmd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_NONE) |=> busy_o);

  p_ac_in_space_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cg_sel_q ? (ac_q <= CG_LAST) : (ac_q <= DD_LAST));

  p_ofs_in_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_q <= DD_LAST);
endmodule

// File: tb/tb_lcd_cmd_exec.sv
module tb_lcd_cmd_exec;
  localparam int SHORT = 3;
  localparam int LONG  = 12;
  localparam int DDN = 80;
  localparam int CGN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, rs = 1'b0;
  logic [7:0] din = 8'h00;

  logic       busy, cg_sel, inc, ash, don, cur, blk, b8, tl, f10;
  logic [6:0] ac, ofs;
  logic [7:0] rdata;

  always #5 clk = ~clk;

  lcd_cmd_exec #(.DD_DEPTH(DDN), .CG_DEPTH(CGN), .SHORT_CYC(SHORT), .LONG_CYC(LONG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .rs_i(rs), .data_i(din),
    .busy_o(busy), .ac_o(ac), .rdata_o(rdata), .cg_sel_o(cg_sel), .inc_o(inc),
    .auto_shift_o(ash), .disp_on_o(don), .cursor_o(cur), .blink_o(blk),
    .bus8_o(b8), .two_line_o(tl), .font10_o(f10), .shift_ofs_o(ofs)
  );

  // behavioural reference model
  byte unsigned m_dd [DDN];
  byte unsigned m_cg [CGN];
  int m_ac, m_ofs, m_busy;
  bit m_cgs, m_inc, m_sh, m_d, m_c, m_b, m_dl, m_n, m_f;
  byte unsigned m_rd;
  bit acc;

  function automatic int stepm(int a, bit up, int n);
    return up ? (a + 1) % n : (a + n - 1) % n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_dd[i]) m_dd[i] = 8'h20;
      foreach (m_cg[i]) m_cg[i] = 8'h00;
      m_ac = 0; m_ofs = 0; m_busy = 0; m_cgs = 0; m_inc = 1; m_sh = 0;
      m_d = 0; m_c = 0; m_b = 0; m_dl = 1; m_n = 0; m_f = 0; m_rd = 0;
    end else begin
      acc = (wr || rd) && (m_busy == 0);
      if (m_busy > 0) m_busy--;
      if (acc) begin
        if (wr && rs) begin
          if (m_cgs) m_cg[m_ac] = din; else m_dd[m_ac] = din;
          if (m_sh && !m_cgs) m_ofs = stepm(m_ofs, m_inc, DDN);
          m_ac = stepm(m_ac, m_inc, m_cgs ? CGN : DDN);
          m_busy = SHORT;
        end else if (wr) begin
          m_busy = SHORT;
          if (din[7]) begin
            m_ac = (din[6:0] >= DDN) ? din[6:0] - DDN : din[6:0];
            m_cgs = 0;
          end else if (din[6]) begin
            m_ac = din[5:0]; m_cgs = 1;
          end else if (din[5]) begin
            m_dl = din[4]; m_n = din[3]; m_f = din[2];
          end else if (din[4]) begin
            if (din[3]) m_ofs = stepm(m_ofs, !din[2], DDN);
            else m_ac = stepm(m_ac, din[2], m_cgs ? CGN : DDN);
          end else if (din[3]) begin
            m_d = din[2]; m_c = din[1]; m_b = din[0];
          end else if (din[2]) begin
            m_inc = din[1]; m_sh = din[0];
          end else if (din[1]) begin
            m_ac = 0; m_ofs = 0; m_cgs = 0; m_busy = LONG;
          end else if (din[0]) begin
            foreach (m_dd[i]) m_dd[i] = 8'h20;
            m_ac = 0; m_ofs = 0; m_cgs = 0; m_inc = 1; m_busy = LONG;
          end else begin
            m_busy = 0;
          end
        end else if (rs) begin
          m_rd = m_cgs ? m_cg[m_ac] : m_dd[m_ac];
          if (m_sh && !m_cgs) m_ofs = stepm(m_ofs, m_inc, DDN);
          m_ac = stepm(m_ac, m_inc, m_cgs ? CGN : DDN);
          m_busy = SHORT;
        end
      end
    end
  end

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic cmp(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      cmp("R11", "busy", int'(busy), int'(m_busy != 0));
      cmp("R7", "ac", int'(ac), m_ac);
      cmp("R8", "rdata", int'(rdata), int'(m_rd));
      cmp("R6", "cg_sel", int'(cg_sel), int'(m_cgs));
      cmp("R4", "mode", int'({inc, ash, don, cur, blk, b8, tl, f10}),
          int'({m_inc, m_sh, m_d, m_c, m_b, m_dl, m_n, m_f}));
      cmp("R10", "ofs", int'(ofs), m_ofs);
    end
  endtask

  task automatic send(bit w, bit r, bit s, logic [7:0] d);
    wr = w; rd = r; rs = s; din = d;
    tick();
    wr = 0; rd = 0;
    while (busy) tick();
  endtask

  task automatic instr(logic [7:0] d); send(1, 0, 0, d); endtask
  task automatic wdat(logic [7:0] d);  send(1, 0, 1, d); endtask
  task automatic rdat();               send(0, 1, 1, 8'h00); endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int cnt;
    repeat (2) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    cmp("R1", "busy", int'(busy), 0);
    cmp("R1", "ac", int'(ac), 0);
    cmp("R1", "mode", int'({inc, ash, don, cur, blk, b8, tl, f10}), 8'b1000_0100);
    cmp("R1", "ofs", int'(ofs), 0);
    cmp("R1", "cg_sel", int'(cg_sel), 0);
    rdat();
    cmp("R1", "dd[0]", int'(rdata), 8'h20);

    // R4 mode registers
    instr(8'h38);
    cmp("R4", "func 38", int'({b8, tl, f10}), 3'b110);
    instr(8'h24);
    cmp("R4", "func 24", int'({b8, tl, f10}), 3'b001);
    instr(8'h0F);
    cmp("R4", "disp 0F", int'({don, cur, blk}), 3'b111);
    instr(8'h0C);
    cmp("R4", "disp 0C", int'({don, cur, blk}), 3'b100);
    instr(8'h06);

    // R11 short busy length
    wr = 1; rs = 0; din = 8'h06; tick(); wr = 0; cnt = 0;
    while (busy) begin cnt++; tick(); end
    cmp("R11", "short busy", cnt, SHORT);

    // R7 increment wrap at 79
    instr(8'h80 | 8'd78);
    wdat(8'h41); wdat(8'h42);
    cmp("R7", "inc wrap dd", int'(ac), 0);
    // R6 address folding
    instr(8'hD0);
    cmp("R6", "dd 80->0", int'(ac), 0);
    instr(8'hFF);
    cmp("R6", "dd 127->47", int'(ac), 47);
    // R7 decrement wrap at 0
    instr(8'h04); instr(8'h80);
    wdat(8'h43);
    cmp("R7", "dec wrap dd", int'(ac), 79);
    // R8 read back
    instr(8'h06); instr(8'h80 | 8'd78);
    rdat();
    cmp("R8", "read 78", int'(rdata), 8'h41);
    rdat();
    cmp("R8", "read 79", int'(rdata), 8'h42);
    cmp("R8", "ac after read", int'(ac), 0);

    // glyph RAM
    instr(8'h40 | 8'd63);
    cmp("R6", "cg addr", int'({cg_sel, ac}), {1'b1, 7'd63});
    wdat(8'h1F);
    cmp("R7", "inc wrap cg", int'(ac), 0);
    instr(8'h7F);
    rdat();
    cmp("R8", "read cg 63", int'(rdata), 8'h1F);

    // R9 auto shift
    instr(8'h02); instr(8'h07); instr(8'h85);
    wdat(8'h51);
    cmp("R9", "ofs +1", int'(ofs), 1);
    instr(8'h40); wdat(8'h11);
    cmp("R9", "cg no shift", int'(ofs), 1);
    instr(8'h05); instr(8'h85); wdat(8'h52);
    cmp("R9", "ofs -1", int'(ofs), 0);
    instr(8'h06);

    // R10 shift commands
    instr(8'h1C);
    cmp("R10", "right wrap", int'(ofs), 79);
    instr(8'h18);
    cmp("R10", "left", int'(ofs), 0);
    instr(8'h8A); instr(8'h14);
    cmp("R10", "cursor right", int'(ac), 11);
    instr(8'h10); instr(8'h10);
    cmp("R10", "cursor left", int'(ac), 9);

    // R5 priority with junk low bits
    instr(8'h1F);
    cmp("R5", "1F shift right", int'(ofs), 79);
    instr(8'h00);
    cmp("R5", "00 no busy", int'(busy), 0);
    instr(8'h7F);
    cmp("R5", "7F cg 63", int'({cg_sel, ac}), {1'b1, 7'd63});
    instr(8'h03);
    cmp("R5", "03 home", int'({cg_sel, ac, ofs}), 0);

    // R12 strobes while busy
    instr(8'h80 | 8'd20);
    wr = 1; rs = 1; din = 8'h66; tick();
    din = 8'h77; tick(); tick();
    wr = 0;
    while (busy) tick();
    cmp("R12", "ac single step", int'(ac), 21);
    rdat();
    cmp("R12", "dd[21] untouched", int'(rdata), 8'h20);
    instr(8'h80 | 8'd20); rdat();
    cmp("R12", "dd[20]", int'(rdata), 8'h66);
    // R11 status strobe
    rd = 1; rs = 0; tick(); rd = 0;
    cmp("R11", "status no busy", int'(busy), 0);

    // R3 home keeps contents
    instr(8'h8A); wdat(8'h99); instr(8'h18);
    wr = 1; rs = 0; din = 8'h02; tick(); wr = 0; cnt = 0;
    while (busy) begin cnt++; tick(); end
    cmp("R11", "long busy home", cnt, LONG);
    cmp("R3", "home ac/ofs", int'({ac, ofs}), 0);
    instr(8'h8A); rdat();
    cmp("R3", "content kept", int'(rdata), 8'h99);

    // R2 clear
    instr(8'h04); instr(8'h1C);
    instr(8'h01);
    cmp("R2", "clear ac/ofs", int'({ac, ofs}), 0);
    cmp("R2", "clear inc", int'(inc), 1);
    for (int i = 0; i < DDN; i++) begin
      rdat();
      cmp("R2", "cleared byte", int'(rdata), 8'h20);
    end
    instr(8'h40); rdat();
    cmp("R2", "cg kept", int'(rdata), 8'h11);

    repeat (3) tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule